// File: doc/BRIEF.md
# Clock Output Controller with PLL Configuration Register

This block holds two registers that configure a clock subsystem: a PLL configuration word, containing a multiplier, enables and a write lock, and a clock-output word that sets the mode of two clock outputs. Software reaches both registers over a plain register bus with an address, write data, a write strobe, combinational read data and a privilege flag. While hardware reset is held, two strap pins are sampled, and they choose the reset values of both registers.

Each clock output is a gated copy of the block's reference clock. The output runs only when the PLL reports lock, reset has been released, and no multiplier rewrite is still waiting for the PLL to relock. In every other case the output is parked low, unless its mode field switches it off, which holds it high. Each output also reports a drive-strength code in thirds of full strength. A write that would make the two strengths add up to more than full strength is refused, and the refusal is flagged. The gate enable of each output is captured only while the reference clock is low, so a change of state never produces a runt pulse.

Top module: `clkout_ctrl`

## Requirements
- R1: Reads and writes of the PLL word (address ADDR_PLL, default 0) are honoured only while `sup` is 1. With `sup` at 0 a write leaves the word unchanged and a read returns 0.
- R2: While bit 15 (write lock) of the PLL word is 1, every write to that word is ignored, including a write that tries to clear bit 15. Only reset clears it.
- R3: While `rst_n` is 0, each clock edge loads defaults from `strap`. The PLL word takes bit 13 (PLL enable) = 1 unless `strap` is 00, bits 15, 14 and 12 = 0, and bits 11..0 = MF_RESET. Output A's mode resets to 11 when `strap` is 01 and to 00 otherwise. Output B's mode resets to 00 when `strap` is 01 and to 11 otherwise.
- R4: The mode codes are 00 full strength, 01 two-thirds, 10 one-third and 11 off. `drive_a` and `drive_b` give the strength in thirds as 3, 2, 1 and 0, in that order.
- R5: A write to the clock-output word (address ADDR_CLKO, default 1) whose two strengths sum to more than 3 is refused. The old value stays, and `wr_err` is 1 for exactly the one cycle after the write edge. An accepted write, from any privilege level, loads output A's mode from bits 1..0 and output B's mode from bits 3..2.
- R6: An output whose mode is 11 is held high.
- R7: An output whose mode is not 11 copies `clk` when `lock_in` is 1, `rst_n` is 1 and no multiplier-change unlock is pending. Otherwise it is low. A condition that holds before a rising edge of `clk` shows up in the high phase that edge starts, because the enable is captured only while `clk` is low.
- R8: An accepted PLL write whose bits 11..0 differ from the stored multiplier sets a pending unlock, which forces the outputs low as in R7. The next rising edge of `lock_in` clears it. If such a write and a rise of `lock_in` fall on the same edge, the unlock is set.
- R9: The clock-output word reads back as bits 3..0 holding the modes, with bits 15..4 reading 0. Any address other than the two register addresses reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference and register clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| strap | input | 2 | Mode pins sampled during reset |
| addr | input | ADDR_W | Register address |
| wdata | input | 16 | Write data |
| we | input | 1 | Write strobe |
| sup | input | 1 | Privileged access flag |
| rdata | output | 16 | Combinational read data |
| lock_in | input | 1 | PLL lock status |
| wr_err | output | 1 | Refused clock-output write, one-cycle pulse |
| clko_a | output | 1 | Gated clock output A |
| clko_b | output | 1 | Gated clock output B |
| drive_a | output | 2 | Drive strength of output A in thirds |
| drive_b | output | 2 | Drive strength of output B in thirds |

## Verification
The case of interest is a multiplier rewrite that lands on the same edge as a rise of `lock_in`. On that edge, setting the pending unlock and clearing it compete, and R8 gives the set priority. The bench provokes it by pulsing the PLL write with a new multiplier in the same low phase in which it raises `lock_in`. A behavioural model then expects both outputs to stay parked until a later, separate lock rise. A second overlap, a refused clock-output write in the same cycle as a multiplier change, is also driven, and `wr_err` and the output gating are each judged on their own.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   localparam int DATA_W  = 16;
   localparam int MF_W    = 12;
   localparam int LOCK_B  = 15;
   localparam int PRE_B   = 14;
   localparam int EN_B    = 13;
   localparam int STOP_B  = 12;
   localparam int MODE_W  = 2;
   localparam int N_OUT   = 2;

   typedef enum logic [MODE_W-1:0] {
      OM_FULL  = 2'b00,
      OM_TWO3  = 2'b01,
      OM_ONE3  = 2'b10,
      OM_OFF   = 2'b11
   } omode_t;

   // strength in thirds: 3,2,1,0 for codes 00..11
   function automatic logic [1:0] drive_of(input logic [MODE_W-1:0] m);
      return 2'd3 - m;
   endfunction

   function automatic logic sum_ok(input logic [MODE_W-1:0] a,
                                   input logic [MODE_W-1:0] b);
      logic [2:0] s;
      s = {1'b0, drive_of(a)} + {1'b0, drive_of(b)};
      return (s <= 3'd3);
   endfunction

endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
   import clkctl_pkg::*;
#(
   parameter int                ADDR_W    = 4,
   parameter int                ADDR_PLL  = 0,
   parameter int                ADDR_CLKO = 1,
   parameter logic [MF_W-1:0]   MF_RESET  = 12'h190
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [1:0]                    strap,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             wdata,
   input  logic                          we,
   input  logic                          sup,
   input  logic                          lock_in,
   output logic [DATA_W-1:0]             rdata,
   output logic [DATA_W-1:0]             pll_q,
   output logic [N_OUT*MODE_W-1:0]       modes_q,
   output logic                          chg_q,
   output logic                          wr_err
);

   localparam logic [ADDR_W-1:0] A_PLL  = ADDR_W'(ADDR_PLL);
   localparam logic [ADDR_W-1:0] A_CLKO = ADDR_W'(ADDR_CLKO);
   localparam int                MODES_W = N_OUT * MODE_W;

   logic                  lock_q;
   logic                  pll_hit, clko_hit, pll_wr, mf_diff, lock_rise;
   logic [DATA_W-1:0]     pll_dflt;
   logic [MODES_W-1:0]    modes_dflt;
   logic [MODE_W-1:0]     new_a, new_b;

   assign pll_hit   = (addr == A_PLL);
   assign clko_hit  = (addr == A_CLKO);
   assign pll_wr    = we && pll_hit && sup && !pll_q[LOCK_B];
   assign mf_diff   = (wdata[MF_W-1:0] != pll_q[MF_W-1:0]);
   assign lock_rise = lock_in && !lock_q;
   assign new_a     = wdata[MODE_W-1:0];
   assign new_b     = wdata[2*MODE_W-1:MODE_W];

   always_comb begin
      pll_dflt           = '0;
      pll_dflt[MF_W-1:0] = MF_RESET;
      pll_dflt[EN_B]     = (strap != 2'b00);
      if (strap == 2'b01) modes_dflt = {OM_FULL, OM_OFF};
      else                modes_dflt = {OM_OFF, OM_FULL};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pll_q   <= pll_dflt;
         modes_q <= modes_dflt;
         chg_q   <= 1'b0;
         lock_q  <= 1'b0;
         wr_err  <= 1'b0;
      end else begin
         lock_q <= lock_in;
         wr_err <= 1'b0;
         if (pll_wr) pll_q <= wdata;
         if (pll_wr && mf_diff) chg_q <= 1'b1;
         else if (lock_rise)    chg_q <= 1'b0;
         if (we && clko_hit) begin
            if (sum_ok(new_a, new_b)) modes_q <= {new_b, new_a};
            else                      wr_err  <= 1'b1;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (pll_hit) begin
         if (sup) rdata = pll_q;
      end else if (clko_hit) begin
         rdata[MODES_W-1:0] = modes_q;
      end
   end

endmodule

// File: rtl/clkctl_gate.sv
module clkctl_gate (
   input  logic clk,
   input  logic run_req,
   input  logic hold_req,
   output logic clk_out
);

   logic run_l;
   logic hold_l;

   // enable captured only during the low phase of the reference clock
   always_latch begin
      if (!clk) begin
         run_l  <= run_req;
         hold_l <= hold_req;
      end
   end

   assign clk_out = hold_l | (clk & run_l);

endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
   import clkctl_pkg::*;
#(
   parameter int              ADDR_W    = 4,
   parameter int              ADDR_PLL  = 0,
   parameter int              ADDR_CLKO = 1,
   parameter logic [11:0]     MF_RESET  = 12'h190
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        strap,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   input  logic              we,
   input  logic              sup,
   output logic [15:0]       rdata,
   input  logic              lock_in,
   output logic              wr_err,
   output logic              clko_a,
   output logic              clko_b,
   output logic [1:0]        drive_a,
   output logic [1:0]        drive_b
);

   localparam int MODES_W = N_OUT * MODE_W;

   initial begin
      if (ADDR_W < 1 || ADDR_W > 16)
         $error("clkout_ctrl: ADDR_W out of range");
      if (ADDR_PLL == ADDR_CLKO)
         $error("clkout_ctrl: register addresses collide");
      if (ADDR_PLL >= (1 << ADDR_W) || ADDR_CLKO >= (1 << ADDR_W))
         $error("clkout_ctrl: register address does not fit ADDR_W");
   end

   logic [DATA_W-1:0]  pll_q;
   logic [MODES_W-1:0] modes_q;
   logic               chg_q;
   logic [N_OUT-1:0]   run_x, hold_x, clk_o;
   logic [1:0]         drv [N_OUT];

   clkctl_regs #(
      .ADDR_W   (ADDR_W),
      .ADDR_PLL (ADDR_PLL),
      .ADDR_CLKO(ADDR_CLKO),
      .MF_RESET (MF_RESET)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap   (strap),
      .addr    (addr),
      .wdata   (wdata),
      .we      (we),
      .sup     (sup),
      .lock_in (lock_in),
      .rdata   (rdata),
      .pll_q   (pll_q),
      .modes_q (modes_q),
      .chg_q   (chg_q),
      .wr_err  (wr_err)
   );

   for (genvar g = 0; g < N_OUT; g++) begin : g_out
      logic [MODE_W-1:0] m;
      assign m        = modes_q[g*MODE_W +: MODE_W];
      assign hold_x[g] = (m == OM_OFF);
      assign run_x[g]  = (m != OM_OFF) && rst_n && lock_in && !chg_q;
      assign drv[g]    = drive_of(m);

      clkctl_gate u_gate (
         .clk      (clk),
         .run_req  (run_x[g]),
         .hold_req (hold_x[g]),
         .clk_out  (clk_o[g])
      );
   end

   assign clko_a  = clk_o[0];
   assign clko_b  = clk_o[1];
   assign drive_a = drv[0];
   assign drive_b = drv[1];

endmodule

// File: rtl/clkout_ctrl_chk.sv
module clkout_ctrl_chk #(
   parameter int ADDR_W   = 4,
   parameter int ADDR_PLL = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              we,
   input logic              sup,
   input logic [15:0]       pll_q,
   input logic [3:0]        modes_q,
   input logic              wr_err,
   input logic              clko_a,
   input logic              clko_b,
   input logic [1:0]        drive_a,
   input logic [1:0]        drive_b
);

   a_r1_user_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !sup && addr == ADDR_W'(ADDR_PLL)) |=> $stable(pll_q));

   a_r2_locked_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      pll_q[15] |=> $stable(pll_q));

   a_r4_strength_budget: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, drive_a} + {1'b0, drive_b}) <= 3'd3);

   a_r5_refused_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $stable(modes_q));

   // low phase just before the edge: a gated output shows only its hold level
   a_r6_hold_high_a: assert property (@(posedge clk) disable iff (!rst_n)
      clko_a == (modes_q[1:0] == 2'b11));

   a_r6_hold_high_b: assert property (@(posedge clk) disable iff (!rst_n)
      clko_b == (modes_q[3:2] == 2'b11));

endmodule

bind clkout_ctrl clkout_ctrl_chk #(
   .ADDR_W  (ADDR_W),
   .ADDR_PLL(ADDR_PLL)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .we      (we),
   .sup     (sup),
   .pll_q   (pll_q),
   .modes_q (modes_q),
   .wr_err  (wr_err),
   .clko_a  (clko_a),
   .clko_b  (clko_b),
   .drive_a (drive_a),
   .drive_b (drive_b)
);

// File: tb/clkout_ctrl_test.sv
`timescale 1ns/1ps
module clkout_ctrl_test;

   localparam int          AW = 4;
   localparam logic [11:0] MFR = 12'h190;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    strap = 2'b00;
   logic [AW-1:0] addr = '0;
   logic [15:0]   wdata = '0;
   logic          we = 1'b0;
   logic          sup = 1'b1;
   logic          lock_in = 1'b0;
   logic [15:0]   rdata;
   logic          wr_err, clko_a, clko_b;
   logic [1:0]    drive_a, drive_b;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   clkout_ctrl #(.ADDR_W(AW), .MF_RESET(MFR)) uut (
      .clk(clk), .rst_n(rst_n), .strap(strap), .addr(addr), .wdata(wdata),
      .we(we), .sup(sup), .rdata(rdata), .lock_in(lock_in), .wr_err(wr_err),
      .clko_a(clko_a), .clko_b(clko_b), .drive_a(drive_a), .drive_b(drive_b)
   );

   task automatic check(input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [15:0] m_pll;
   logic [1:0]  m_ma, m_mb;
   logic        m_err, m_chg, m_lockq;
   bit          m_ok = 0;

   function automatic int strength(input logic [1:0] m);
      case (m)
         2'b00:   return 3;
         2'b01:   return 2;
         2'b10:   return 1;
         default: return 0;
      endcase
   endfunction

   function automatic logic [15:0] exp_read();
      if (addr == 0)      return sup ? m_pll : 16'h0;
      else if (addr == 1) return {12'h0, m_mb, m_ma};
      else                return 16'h0;
   endfunction

   always @(posedge clk) begin
      bit      valid;
      logic    ea, eb;
      valid = m_ok;
      ea = (m_ma == 2'b11) || (rst_n && lock_in && !m_chg);
      eb = (m_mb == 2'b11) || (rst_n && lock_in && !m_chg);
      if (!rst_n) begin
         m_pll = {2'b00, strap != 2'b00, 1'b0, MFR};
         m_ma  = (strap == 2'b01) ? 2'b11 : 2'b00;
         m_mb  = (strap == 2'b01) ? 2'b00 : 2'b11;
         m_err = 0; m_chg = 0; m_lockq = 0; m_ok = 1;
      end else if (m_ok) begin
         bit rise, pw;
         rise = lock_in && !m_lockq;
         pw   = we && addr == 0 && sup && !m_pll[15];
         m_lockq = lock_in;
         m_err   = 0;
         if (pw && wdata[11:0] != m_pll[11:0]) m_chg = 1;
         else if (rise)                        m_chg = 0;
         if (pw) m_pll = wdata;
         if (we && addr == 1) begin
            if (strength(wdata[1:0]) + strength(wdata[3:2]) <= 3) begin
               m_ma = wdata[1:0]; m_mb = wdata[3:2];
            end else m_err = 1;
         end
      end
      #5;
      if (valid && !done) begin
         check("R6 R7 R8 clko_a high phase", {15'h0, clko_a}, {15'h0, ea});
         check("R6 R7 R8 clko_b high phase", {15'h0, clko_b}, {15'h0, eb});
      end
      if (m_ok && !done) begin
         check("R1 R2 R3 R9 rdata", rdata, exp_read());
         check("R4 drive_a", {14'h0, drive_a}, 16'(strength(m_ma)));
         check("R4 drive_b", {14'h0, drive_b}, 16'(strength(m_mb)));
         if (rst_n) check("R5 wr_err", {15'h0, wr_err}, {15'h0, m_err});
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(input logic [AW-1:0] a, input logic [15:0] d,
                     input logic s);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1; sup = s;
      @(negedge clk);
      we = 1'b0; sup = 1'b1;
   endtask

   task automatic do_reset(input logic [1:0] p);
      @(negedge clk);
      rst_n = 1'b0; strap = p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      for (int p = 0; p < 4; p++) begin
         do_reset(2'(p));
         addr = 0; sup = 1'b1;
         #2 check("R3 pll default", rdata,
                  {2'b00, (p != 0) ? 1'b1 : 1'b0, 1'b0, MFR});
         addr = 1;
         #1 check("R3 mode default", rdata,
                  (p == 1) ? 16'h0003 : 16'h000C);
         addr = 0;
      end

      do_reset(2'b00);
      lock_in = 1'b1;
      idle(4);
      check("R7 running output toggles low phase", {15'h0, clko_a}, 16'h0);

      // R5: 00 with 01 is over budget
      wr(1, 16'h0004, 1'b1);
      #6 check("R5 err pulse", {15'h0, wr_err}, 16'h1);
      idle(1);
      wr(1, 16'h0006, 1'b1);          // A=10, B=01
      wr(1, 16'hFFF9, 1'b0);          // B=10 A=01, junk high bits, user mode
      addr = 1; #2 check("R9 high bits read zero", rdata, 16'h0009);
      idle(2);

      // R1: user-mode access to PLL word
      wr(0, 16'h2055, 1'b0);
      addr = 0; sup = 1'b0;
      #2 check("R1 user read is zero", rdata, 16'h0);
      sup = 1'b1;
      idle(1);

      // R8: multiplier change parks outputs until lock rises
      wr(0, {4'b0010, 12'h123}, 1'b1);
      idle(3);
      lock_in = 1'b0; idle(2);
      lock_in = 1'b1; idle(3);
      wr(0, {4'b0110, 12'h123}, 1'b1); // same multiplier: no unlock
      idle(2);

      // R8: change write on the same edge as a lock rise
      lock_in = 1'b0; idle(2);
      @(negedge clk);
      addr = 0; wdata = {4'b0010, 12'h456}; we = 1'b1; sup = 1'b1;
      lock_in = 1'b1;
      @(negedge clk); we = 1'b0;
      idle(3);
      lock_in = 1'b0; idle(1);
      lock_in = 1'b1; idle(3);

      // overlap: refused output write together with multiplier change
      @(negedge clk);
      addr = 1; wdata = 16'h0000; we = 1'b1;
      @(negedge clk);
      addr = 0; wdata = {4'b0010, 12'h789}; we = 1'b1;
      @(negedge clk); we = 1'b0;
      idle(2);
      lock_in = 1'b0; idle(1); lock_in = 1'b1; idle(2);

      // R6: both outputs off, then other addresses
      wr(1, 16'h000F, 1'b0);
      idle(2);
      addr = 4'h7; #2 check("R9 unmapped reads zero", rdata, 16'h0);
      idle(1);

      // R2: write lock
      wr(0, {4'b1010, 12'h321}, 1'b1);
      wr(0, {4'b0010, 12'hABC}, 1'b1);
      addr = 0; sup = 1'b1;
      #2 check("R2 locked word unchanged", rdata, {4'b1010, 12'h321});
      idle(2);

      // R7: reset asserted with lock high parks a running output
      wr(1, 16'h000C, 1'b1);          // A full, B off
      idle(2);
      @(negedge clk); rst_n = 1'b0; strap = 2'b10;
      idle(3);
      rst_n = 1'b1;
      idle(4);

      done = 1;
      #1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog R7 actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule